// File: doc/BRIEF.md
# Bang-Bang Phase Quantizer

The block compares a reference clock with a divided feedback clock once per period and reports a signed phase-error word. It looks only at the rising edges of the two inputs. Both inputs are brought into a fast sampling clock domain, and each rising edge becomes a one-cycle event. The first event to arrive starts a timing run and fixes the sign of the result. The run then counts sampling cycles until the other input's event arrives.

When the run closes, the sign and the saturating count are merged into a two's-complement word of `MAG_W+1` bits. That word is presented together with a one-cycle valid strobe. A loop filter downstream can take the word as a proportional error sample. A positive value means the reference is ahead, and a negative value means the feedback is ahead. After each result the block re-arms and waits for the next pair of edges.

Top module: `phase_quant_top`

## Requirements
- R1: While `rst_ni` is low, `err_o` is 0 and `err_vld_o` is 0.
- R2: If the reference rising edge is seen d sampling cycles before the feedback rising edge (0 < d < 2^MAG_W), the strobed word is +d, with sign bit `err_o[MAG_W]` equal to 0.
- R3: If the feedback rising edge is seen d sampling cycles before the reference rising edge (0 < d < 2^MAG_W), the strobed word is −d in two's complement, with sign bit `err_o[MAG_W]` equal to 1.
- R4: If both rising edges are seen in the same sampling cycle, the strobed word is 0 and its sign bit is 0.
- R5: The magnitude saturates at 2^MAG_W − 1 (63 by default) for either sign. Larger separations give +63 or −63, and the code −64 never appears.
- R6: `err_vld_o` is high for exactly one sampling cycle per completed edge pair. `err_o` is 0 in every cycle in which `err_vld_o` is low.
- R7: During a timing run, further rising edges of the leading input are ignored. The separation is measured from that input's first edge.
- R8: `err_vld_o` rises in the cycle after the fourth rising clock edge at which the later input is sampled high, counting that edge as the first. An internal decision leads the strobe by exactly one cycle.
- R9: After each result the block re-arms, so later edge pairs are measured independently of earlier ones, including after a saturated run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to `clk_i` |
| ref_i | input | 1 | Reference clock, asynchronous to `clk_i` |
| fb_i | input | 1 | Divided feedback clock, asynchronous to `clk_i` |
| err_o | output | MAG_W+1 | Signed phase-error word, two's complement |
| err_vld_o | output | 1 | One-cycle strobe marking a new `err_o` |

## Verification
The checker watches several properties on every cycle:
- the strobe is never high for two cycles in a row;
- the output word is zero whenever the strobe is low;
- the most negative code never appears;
- the output strobe follows an internal decision by exactly one cycle;
- a pair of edges that arrive in the same cycle from the armed state yields a zero word two cycles later.

The actual magnitude and sign for a given edge spacing need the bench's scenarios. So do saturation at both signs, the rejection of a repeated leading edge, the end-to-end latency through the synchronizers, and re-arming after a saturated run. The bench drives these and compares the outputs against its own cycle model.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Index of each input in the synchronized event vector
  localparam int unsigned NUM_IN = 2;
  localparam int unsigned IDX_REF = 0;
  localparam int unsigned IDX_FB  = 1;

  // Race controller states
  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_TIMING = 1'b1
  } race_st_e;

endpackage

// File: rtl/pq_edge_sync.sv
module pq_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // The last synchronizer stage is high and the extra history flop is low
  assign rise_o = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/pq_race.sv
module pq_race
  import pq_pkg::*;
#(
  parameter int unsigned MAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_ref_i,
  input  logic             rise_fb_i,
  output logic             done_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             armed_o
);

  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};
  localparam logic [MAG_W-1:0] MAG_ONE = MAG_W'(1);

  race_st_e         st_q, st_d;
  logic [MAG_W-1:0] cnt_q, cnt_d;
  logic             lead_fb_q, lead_fb_d;
  logic             done_q, done_d;
  logic             sign_q, sign_d;
  logic [MAG_W-1:0] mag_q, mag_d;
  logic             cnt_en, lead_en, res_en;
  logic             closing;

  // The closing event is the edge of whichever input did not start the run
  assign closing = lead_fb_q ? rise_ref_i : rise_fb_i;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    lead_fb_d = lead_fb_q;
    done_d    = 1'b0;
    sign_d    = sign_q;
    mag_d     = mag_q;
    cnt_en    = 1'b0;
    lead_en   = 1'b0;
    unique case (st_q)
      ST_ARMED: begin
        if (rise_ref_i && rise_fb_i) begin
          done_d = 1'b1;
          sign_d = 1'b0;
          mag_d  = '0;
        end else if (rise_ref_i || rise_fb_i) begin
          st_d      = ST_TIMING;
          lead_fb_d = rise_fb_i;
          lead_en   = 1'b1;
          cnt_d     = MAG_ONE;
          cnt_en    = 1'b1;
        end
      end
      ST_TIMING: begin
        if (closing) begin
          done_d = 1'b1;
          sign_d = lead_fb_q;
          mag_d  = cnt_q;
          st_d   = ST_ARMED;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end else if (cnt_q != MAG_MAX) begin
          cnt_d  = cnt_q + MAG_ONE;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_ARMED;
    endcase
    res_en = done_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ARMED;
      cnt_q     <= '0;
      lead_fb_q <= 1'b0;
      done_q    <= 1'b0;
      sign_q    <= 1'b0;
      mag_q     <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (lead_en) begin
        lead_fb_q <= lead_fb_d;
      end
      if (res_en) begin
        sign_q <= sign_d;
        mag_q  <= mag_d;
      end
    end
  end

  assign done_o  = done_q;
  assign sign_o  = sign_q;
  assign mag_o   = mag_q;
  assign armed_o = (st_q == ST_ARMED);

endmodule

// File: rtl/pq_merge.sv
module pq_merge #(
  parameter int unsigned MAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic             sign_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W:0]   err_o,
  output logic             vld_o
);

  localparam int unsigned WORD_W = MAG_W + 1;

  logic [WORD_W-1:0] mag_ext;
  logic [WORD_W-1:0] err_d, err_q;
  logic              vld_q;

  always_comb begin
    mag_ext = {1'b0, mag_i};
    if (!done_i) begin
      err_d = '0;
    end else if (sign_i) begin
      err_d = ~mag_ext + WORD_W'(1);
    end else begin
      err_d = mag_ext;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      vld_q <= 1'b0;
    end else begin
      err_q <= err_d;
      vld_q <= done_i;
    end
  end

  assign err_o = err_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/phase_quant_top.sv
module phase_quant_top
  import pq_pkg::*;
#(
  parameter int unsigned MAG_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ref_i,
  input  logic           fb_i,
  output logic [MAG_W:0] err_o,
  output logic           err_vld_o
);

  logic [NUM_IN-1:0] in_vec;
  logic [NUM_IN-1:0] rise_vec;
  logic              race_done;
  logic              race_sign;
  logic [MAG_W-1:0]  race_mag;
  logic              race_armed;

  assign in_vec[IDX_REF] = ref_i;
  assign in_vec[IDX_FB]  = fb_i;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_sync
    pq_edge_sync #(
      .SYNC_STAGES(SYNC_STAGES)
    ) sync_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(in_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  pq_race #(
    .MAG_W(MAG_W)
  ) race_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_ref_i(rise_vec[IDX_REF]),
    .rise_fb_i (rise_vec[IDX_FB]),
    .done_o    (race_done),
    .sign_o    (race_sign),
    .mag_o     (race_mag),
    .armed_o   (race_armed)
  );

  pq_merge #(
    .MAG_W(MAG_W)
  ) merge_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(race_done),
    .sign_i(race_sign),
    .mag_i (race_mag),
    .err_o (err_o),
    .vld_o (err_vld_o)
  );

endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int unsigned MAG_W = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [MAG_W:0] err_o,
  input logic           err_vld_o,
  input logic           race_done,
  input logic           race_armed,
  input logic           rise_ref,
  input logic           rise_fb
);

  localparam logic [MAG_W:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  // R6
  single_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |=> !err_vld_o);

  // R6
  quiet_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_vld_o |-> (err_o == '0));

  // R5
  mag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> (err_o != MOST_NEG));

  // R8
  decide_to_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    race_done |=> err_vld_o);

  // R8
  strobe_from_decide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> $past(race_done));

  // R4
  tie_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (race_armed && rise_ref && rise_fb) |=> ##1 (err_vld_o && (err_o == '0)));

endmodule

bind phase_quant_top pq_checker #(
  .MAG_W(MAG_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .err_o     (err_o),
  .err_vld_o (err_vld_o),
  .race_done (race_done),
  .race_armed(race_armed),
  .rise_ref  (rise_vec[pq_pkg::IDX_REF]),
  .rise_fb   (rise_vec[pq_pkg::IDX_FB])
);

// File: tb/phase_quant_top_tb_top.sv
module phase_quant_top_tb_top;

  localparam int MAG_W = 6;
  localparam int MAXV  = (1 << MAG_W) - 1;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ref_in = 1'b0;
  logic           fb_in = 1'b0;
  logic [MAG_W:0] err;
  logic           vld;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  finished = 0;

  always #10 clk = ~clk;

  phase_quant_top #(.MAG_W(MAG_W)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .ref_i    (ref_in),
    .fb_i     (fb_in),
    .err_o    (err),
    .err_vld_o(vld)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: input history, timestamp of the first event,
  // and a one-step output delay
  int hr[4];
  int hf[4];
  int cyc = 0;
  bit busy = 0;
  bit lead_fb = 0;
  int t_first = 0;
  bit pend_v = 0;
  int pend_e = 0;
  bit exp_v = 0;
  int exp_e = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        hr[i] = 0;
        hf[i] = 0;
      end
      busy = 0; pend_v = 0; pend_e = 0; exp_v = 0; exp_e = 0; cyc = 0;
    end else begin
      bit er, ef;
      int d;
      cyc++;
      exp_v = pend_v;
      exp_e = pend_e;
      pend_v = 0;
      pend_e = 0;
      for (int i = 3; i > 0; i--) begin
        hr[i] = hr[i-1];
        hf[i] = hf[i-1];
      end
      hr[0] = int'(ref_in);
      hf[0] = int'(fb_in);
      er = (hr[2] == 1) && (hr[3] == 0);
      ef = (hf[2] == 1) && (hf[3] == 0);
      if (!busy) begin
        if (er && ef) begin
          pend_v = 1;
          pend_e = 0;
        end else if (er || ef) begin
          busy = 1;
          lead_fb = ef;
          t_first = cyc;
        end
      end else if ((lead_fb && er) || (!lead_fb && ef)) begin
        d = cyc - t_first;
        if (d > MAXV) d = MAXV;
        pend_v = 1;
        pend_e = lead_fb ? -d : d;
        busy = 0;
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R6", "strobe", int'(vld), int'(exp_v));
      chk(exp_e < 0 ? "R3" : "R2", "word", int'($signed(err)), exp_e);
    end
  end

  // Drive one edge pair. The later input rises gap cycles after the first.
  task automatic do_pair(input int gap, input bit fb_first, input int exp, input string req);
    @(negedge clk);
    if (gap == 0) begin
      ref_in = 1'b1;
      fb_in = 1'b1;
    end else begin
      if (fb_first) fb_in = 1'b1; else ref_in = 1'b1;
      repeat (gap) @(negedge clk);
      if (fb_first) ref_in = 1'b1; else fb_in = 1'b1;
    end
    repeat (3) @(negedge clk);
    chk("R8", "strobe before latency", int'(vld), 0);
    @(negedge clk);
    chk("R8", "strobe at latency", int'(vld), 1);
    chk(req, "strobed word", int'($signed(err)), exp);
    ref_in = 1'b0;
    fb_in = 1'b0;
    @(negedge clk);
    chk("R6", "strobe after pulse", int'(vld), 0);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1
    chk("R1", "reset strobe", int'(vld), 0);
    chk("R1", "reset word", int'(err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_pair(5, 1'b0, 5, "R2");
    do_pair(3, 1'b1, -3, "R3");
    do_pair(0, 1'b0, 0, "R4");
    do_pair(1, 1'b1, -1, "R3");
    do_pair(1, 1'b0, 1, "R2");
    do_pair(63, 1'b0, 63, "R5");
    do_pair(64, 1'b1, -63, "R5");
    do_pair(100, 1'b0, 63, "R5");
    // R9: pairs that follow a saturated run are measured fresh
    do_pair(17, 1'b0, 17, "R9");
    do_pair(2, 1'b1, -2, "R9");

    // R7: a second leading edge inside the run is ignored
    @(negedge clk);
    ref_in = 1'b1;
    repeat (2) @(negedge clk);
    ref_in = 1'b0;
    repeat (2) @(negedge clk);
    ref_in = 1'b1;
    repeat (5) @(negedge clk);
    fb_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7", "strobe", int'(vld), 1);
    chk("R7", "word from first edge", int'($signed(err)), 9);
    ref_in = 1'b0;
    fb_in = 1'b0;
    repeat (8) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule